// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits between a set of interrupting devices and a simple processor core. Each maskable request line has a fixed priority, and one extra non-maskable line ranks above all of them. Request lines pass through one register stage. The block then evaluates them only on cycles where the core marks the start of an instruction. A request wins only if its priority is strictly above the priority now in service. The winner is presented to the core, and after the core acknowledges, the block asks the winning device for a vector. It then hands the core a handler address formed from a vector base and that vector.

Service nests. When a handler is entered, the block sets an in-service bit for the source. It pushes the interrupted priority onto a stack that has one entry per priority level, and raises the current priority. A return strobe from the core pops the stack and clears the in-service bit of the level that finished. If the device supplies no vector within a configurable number of cycles, the block reports a bus error for one cycle instead of dispatching. In that case nothing is pushed.

The controller is a five-state machine:
- `S_IDLE` waits for a request it can accept.
- `S_REQ` holds the request to the core.
- `S_VEC` acknowledges the device and counts toward the timeout.
- `S_DISP` presents the handler address.
- `S_BERR` signals the missed vector.

Its transitions are:
- IDLE→REQ, taken on an instruction start with an eligible winner.
- REQ→VEC, taken on `cpu_ack`.
- VEC→DISP, taken on `dev_vec_valid`.
- VEC→BERR, taken when the timeout expires.
- DISP→IDLE and BERR→IDLE, both unconditional.

Top module: `prio_vec_intc`

## Requirements
- R1: Each request line passes through one register stage. A winner is taken only on a cycle with `insn_start` high. With `insn_start` held high, `cpu_irq` rises two clock edges after a request is first driven. With `insn_start` low, the block stays idle.
- R2: A request is accepted only if its priority is strictly greater than `cur_prio`. Requests of lower or equal priority stay pending and are taken after returns lower `cur_prio`.
- R3: Maskable source i has priority i+1, and the non-maskable line has priority NSRC+1. Among simultaneous eligible requests the highest priority wins. `dev_ack` is one-hot: bit i for source i, and bit NSRC for the non-maskable line.
- R4: With `glb_en` low, no maskable source is taken. The non-maskable line is taken regardless of `glb_en`.
- R5: `cpu_irq` stays high until `cpu_ack`, and `dev_ack` is then high until `dev_vec_valid`. On the next cycle `handler_valid` is high for exactly one cycle. At that point `handler_addr` equals `vec_base + 4*dev_vec`, modulo 2^ADDR_W.
- R6: If `dev_vec_valid` does not arrive, `dev_ack` stays high for exactly TIMEOUT cycles. The next cycle has `bus_err` high for one cycle, and `cur_prio` and `isr_latch` are unchanged.
- R7: On dispatch, bit (p-1) of `isr_latch` is set, where p is the accepted priority. The prior `cur_prio` is pushed, and `cur_prio` becomes p.
- R8: An `rti` pulse while idle pops the stack into `cur_prio` and clears the latch bit of the level that was active. An `rti` with an empty stack changes nothing.
- R9: The stack holds NSRC+1 entries. `nest_ovf` is a sticky flag set by a push into a full stack, so it stays low even through nesting at every priority level.
- R10: After reset, the block is idle: `cur_prio` is 0, `isr_latch` is 0, `nest_ovf` is 0, and every handshake output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | NSRC | Maskable request lines, bit i has priority i+1 |
| nmi_req | input | 1 | Non-maskable request line |
| glb_en | input | 1 | Global enable for maskable sources |
| insn_start | input | 1 | Instruction boundary strobe from the core |
| cpu_ack | input | 1 | Core acknowledge of `cpu_irq` |
| rti | input | 1 | Return-from-interrupt strobe |
| vec_base | input | ADDR_W | Base address of the handler table |
| dev_vec | input | VEC_W | Vector supplied by the acknowledged device |
| dev_vec_valid | input | 1 | Vector valid strobe from the device |
| cpu_irq | output | 1 | Interrupt request to the core |
| dev_ack | output | NSRC+1 | One-hot acknowledge to the winning device |
| handler_valid | output | 1 | Handler address valid, one cycle |
| handler_addr | output | ADDR_W | Handler address |
| bus_err | output | 1 | Vector timeout indication, one cycle |
| cur_prio | output | PW | Priority now in service, 0 when none |
| isr_latch | output | NSRC+1 | In-service bit per source |
| nest_ovf | output | 1 | Sticky nesting stack overflow |

## Verification
A corrupted stack entry appears on `cur_prio` on the very `rti` that pops it. One cycle after that, it shows up as a wrong arbitration: a pending lower request is taken too early, or is held back too long. A wrong winner register shows on `dev_ack` one cycle after `cpu_ack`, and again on `isr_latch` two cycles later. A wrong timeout count moves the cycle in which `bus_err` rises. Sweeping every source against every vector value, across nested and cascaded sequences, makes each of these show up within a few cycles of the fault.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_REQ,
        S_VEC,
        S_DISP,
        S_BERR
    } pvic_state_e;
endpackage

// File: rtl/pvic_sync.sv
module pvic_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter #(
    parameter int NSRC = 4,
    parameter int PW   = 3,
    parameter int IW   = 3
) (
    input  logic [NSRC-1:0] req,
    input  logic            nmi,
    input  logic            en,
    input  logic [PW-1:0]   cur_prio,
    output logic            eligible,
    output logic [IW-1:0]   win_id,
    output logic [PW-1:0]   win_prio
);
    logic found;

    always_comb begin
        found    = 1'b0;
        win_id   = '0;
        win_prio = '0;
        if (nmi) begin
            found    = 1'b1;
            win_id   = IW'(NSRC);
            win_prio = PW'(NSRC + 1);
        end else begin
            // ascending scan: the last hit is the highest priority
            for (int i = 0; i < NSRC; i++) begin
                if (req[i] && en) begin
                    found    = 1'b1;
                    win_id   = IW'(i);
                    win_prio = PW'(i + 1);
                end
            end
        end
        eligible = found && (win_prio > cur_prio);
    end
endmodule

// File: rtl/pvic_nest.sv
module pvic_nest #(
    parameter int NSRC = 4,
    parameter int PW   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [PW-1:0]      new_prio,
    input  logic               pop,
    output logic [PW-1:0]      cur_prio,
    output logic [NSRC:0]      latch,
    output logic               ovf
);
    localparam int LEVELS = NSRC + 1;
    localparam int SPW    = $clog2(LEVELS + 1);

    logic [PW-1:0]  stk [LEVELS];
    logic [SPW-1:0] sp;
    logic           full;

    assign full = (sp == SPW'(LEVELS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp       <= '0;
            cur_prio <= '0;
            latch    <= '0;
            ovf      <= 1'b0;
            for (int i = 0; i < LEVELS; i++) stk[i] <= '0;
        end else if (push) begin
            if (full) begin
                ovf <= 1'b1;
            end else begin
                stk[sp]  <= cur_prio;
                sp       <= sp + 1'b1;
                cur_prio <= new_prio;
                latch    <= latch | (LEVELS'(1) << (new_prio - 1'b1));
            end
        end else if (pop && sp != '0) begin
            sp       <= sp - 1'b1;
            cur_prio <= stk[sp - 1'b1];
            latch    <= latch & ~(LEVELS'(1) << (cur_prio - 1'b1));
        end
    end

    // R9: legal nesting never fills past one entry per level
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf);

    // R8: a pop into a non-empty stack strictly lowers the priority
    p_pop_lowers_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && sp != '0) |=> (cur_prio < $past(cur_prio)));

    // R7: a push adds exactly one in-service bit
    p_push_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full) |=> ($countones(latch) == $past($countones(latch)) + 1));
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
    import pvic_pkg::*;
#(
    parameter int NSRC    = 4,
    parameter int VEC_W   = 8,
    parameter int ADDR_W  = 16,
    parameter int TIMEOUT = 6,
    localparam int PW     = $clog2(NSRC + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_req,
    input  logic              nmi_req,
    input  logic              glb_en,
    input  logic              insn_start,
    input  logic              cpu_ack,
    input  logic              rti,
    input  logic [ADDR_W-1:0] vec_base,
    input  logic [VEC_W-1:0]  dev_vec,
    input  logic              dev_vec_valid,
    output logic              cpu_irq,
    output logic [NSRC:0]     dev_ack,
    output logic              handler_valid,
    output logic [ADDR_W-1:0] handler_addr,
    output logic              bus_err,
    output logic [PW-1:0]     cur_prio,
    output logic [NSRC:0]     isr_latch,
    output logic              nest_ovf
);
    localparam int IW = $clog2(NSRC + 1);
    localparam int TW = $clog2(TIMEOUT + 1);

    pvic_state_e       state, state_nx;
    logic [NSRC:0]     sync_q;
    logic              eligible;
    logic [IW-1:0]     arb_id, win_id_q;
    logic [PW-1:0]     arb_prio, win_prio_q;
    logic [TW-1:0]     timer;
    logic [ADDR_W-1:0] addr_q;
    logic              push, pop;

    pvic_sync #(.W(NSRC + 1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({nmi_req, irq_req}),
        .q     (sync_q)
    );

    pvic_arbiter #(.NSRC(NSRC), .PW(PW), .IW(IW)) u_arb (
        .req      (sync_q[NSRC-1:0]),
        .nmi      (sync_q[NSRC]),
        .en       (glb_en),
        .cur_prio (cur_prio),
        .eligible (eligible),
        .win_id   (arb_id),
        .win_prio (arb_prio)
    );

    assign push = (state == S_DISP);
    assign pop  = rti && (state == S_IDLE);

    pvic_nest #(.NSRC(NSRC), .PW(PW)) u_nest (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .new_prio (win_prio_q),
        .pop      (pop),
        .cur_prio (cur_prio),
        .latch    (isr_latch),
        .ovf      (nest_ovf)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (insn_start && eligible) state_nx = S_REQ;
            S_REQ:  if (cpu_ack) state_nx = S_VEC;
            S_VEC: begin
                if (dev_vec_valid)                    state_nx = S_DISP;
                else if (timer == TW'(TIMEOUT - 1))   state_nx = S_BERR;
            end
            S_DISP: state_nx = S_IDLE;
            S_BERR: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_id_q   <= '0;
            win_prio_q <= '0;
            timer      <= '0;
            addr_q     <= '0;
        end else begin
            if (state == S_IDLE && insn_start && eligible) begin
                win_id_q   <= arb_id;
                win_prio_q <= arb_prio;
            end
            if (state == S_VEC) timer <= timer + 1'b1;
            else                timer <= '0;
            if (state == S_VEC && dev_vec_valid)
                addr_q <= vec_base + (ADDR_W'(dev_vec) << 2);
        end
    end

    // outputs
    always_comb begin
        cpu_irq       = 1'b0;
        dev_ack       = '0;
        handler_valid = 1'b0;
        bus_err       = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_REQ:  cpu_irq = 1'b1;
            S_VEC:  dev_ack = (NSRC + 1)'(1) << win_id_q;
            S_DISP: handler_valid = 1'b1;
            S_BERR: bus_err = 1'b1;
            default: ;
        endcase
    end
    assign handler_addr = addr_q;

    // R3: at most one device acknowledged
    p_ack_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_ack));

    // R1: no recognition off an instruction boundary
    p_gate_insn_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !insn_start) |=> (state == S_IDLE));

    // R2: an ineligible winner leaves the block idle
    p_strict_prio_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !eligible) |=> (state == S_IDLE));

    // R4: the non-maskable line is taken whatever the enable
    p_nmi_unmasked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && insn_start && sync_q[NSRC] && cur_prio != PW'(NSRC + 1))
        |=> (state == S_REQ));

    // R6: a timeout neither pushes nor latches
    p_berr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BERR) |=> ($stable(cur_prio) && $stable(isr_latch)));

    // R7: dispatch raises the priority in service
    p_disp_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DISP) |=> (cur_prio > $past(cur_prio)));
endmodule

// File: tb/sim_prio_vec_intc.sv
module sim_prio_vec_intc;
    localparam int NSRC = 4;
    localparam int VW   = 8;
    localparam int AW   = 16;
    localparam int TO   = 6;
    localparam int PW   = $clog2(NSRC + 2);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] irq_req = '0;
    logic            nmi_req = 1'b0;
    logic            glb_en = 1'b1;
    logic            insn_start = 1'b1;
    logic            cpu_ack = 1'b0;
    logic            rti = 1'b0;
    logic [AW-1:0]   vec_base = '0;
    logic [VW-1:0]   dev_vec = '0;
    logic            dev_vec_valid = 1'b0;
    logic            cpu_irq;
    logic [NSRC:0]   dev_ack;
    logic            handler_valid;
    logic [AW-1:0]   handler_addr;
    logic            bus_err;
    logic [PW-1:0]   cur_prio;
    logic [NSRC:0]   isr_latch;
    logic            nest_ovf;

    int compared = 0;
    int mismatched = 0;
    logic [NSRC:0] exp_latch = '0;

    prio_vec_intc #(.NSRC(NSRC), .VEC_W(VW), .ADDR_W(AW), .TIMEOUT(TO)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_req(nmi_req),
        .glb_en(glb_en), .insn_start(insn_start), .cpu_ack(cpu_ack), .rti(rti),
        .vec_base(vec_base), .dev_vec(dev_vec), .dev_vec_valid(dev_vec_valid),
        .cpu_irq(cpu_irq), .dev_ack(dev_ack), .handler_valid(handler_valid),
        .handler_addr(handler_addr), .bus_err(bus_err), .cur_prio(cur_prio),
        .isr_latch(isr_latch), .nest_ovf(nest_ovf)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic raise(input int idx);
        if (idx == NSRC) nmi_req = 1'b1; else irq_req[idx] = 1'b1;
    endtask

    task automatic drop(input int idx);
        if (idx == NSRC) nmi_req = 1'b0; else irq_req[idx] = 1'b0;
    endtask

    // full handshake for the expected winner idx; device drops its line on ack
    task automatic serve(input int idx, input logic [VW-1:0] vec);
        int n;
        logic [AW-1:0] ea;
        n = 0;
        while (!cpu_irq && n < 12) begin @(negedge clk); n++; end
        check("R1 cpu_irq raised", cpu_irq, 1);
        cpu_ack = 1'b1;
        @(negedge clk);
        cpu_ack = 1'b0;
        check("R3 dev_ack winner", dev_ack, 32'(1) << idx);
        check("R5 cpu_irq cleared after ack", cpu_irq, 0);
        drop(idx);
        dev_vec = vec;
        dev_vec_valid = 1'b1;
        @(negedge clk);
        dev_vec_valid = 1'b0;
        ea = vec_base + AW'(32'(vec) * 4);
        check("R5 handler_valid", handler_valid, 1);
        check("R5 handler_addr", handler_addr, ea);
        @(negedge clk);
        check("R5 handler_valid one cycle", handler_valid, 0);
        exp_latch[idx] = 1'b1;
        check("R7 cur_prio after entry", cur_prio, idx + 1);
        check("R7 isr_latch after entry", isr_latch, exp_latch);
    endtask

    task automatic do_rti(input int exp_prio, input int done_idx);
        rti = 1'b1;
        @(negedge clk);
        rti = 1'b0;
        if (done_idx >= 0) exp_latch[done_idx] = 1'b0;
        check("R8 cur_prio after return", cur_prio, exp_prio);
        check("R8 isr_latch after return", isr_latch, exp_latch);
    endtask

    task automatic quiet(input int cycles, input string tag);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            check(tag, cpu_irq, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 cur_prio", cur_prio, 0);
        check("R10 isr_latch", isr_latch, 0);
        check("R10 nest_ovf", nest_ovf, 0);
        check("R10 handshake", {cpu_irq, dev_ack, handler_valid, bus_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle after release", cpu_irq, 0);

        // R8 return with empty stack changes nothing
        do_rti(0, -1);

        // R1 latency: two edges from request to cpu_irq
        raise(1);
        @(negedge clk);
        check("R1 not yet after one edge", cpu_irq, 0);
        @(negedge clk);
        check("R1 raised after two edges", cpu_irq, 1);
        serve(1, 8'h10);
        do_rti(0, 1);

        // R1 no recognition without instruction start
        insn_start = 1'b0;
        raise(2);
        quiet(5, "R1 held without insn_start");
        insn_start = 1'b1;
        serve(2, 8'h22);
        do_rti(0, 2);

        // R5 sweep every source against every vector
        for (int s = 0; s <= NSRC; s++) begin
            vec_base = (s == NSRC) ? 16'hFE00 : AW'(16'h1000 + s * 16'h0404);
            for (int v = 0; v < 256; v++) begin
                raise(s);
                serve(s, VW'(v));
                do_rti(0, s);
            end
        end
        vec_base = 16'h2000;

        // R4 enable masks maskable but not the non-maskable line
        glb_en = 1'b0;
        raise(3);
        quiet(5, "R4 masked source ignored");
        raise(NSRC);
        serve(NSRC, 8'h01);
        do_rti(0, NSRC);
        quiet(3, "R4 still masked after nmi");
        glb_en = 1'b1;
        serve(3, 8'h33);
        do_rti(0, 3);

        // R3 simultaneous requests cascade in priority order
        for (int s = 0; s < NSRC; s++) raise(s);
        for (int s = NSRC - 1; s >= 0; s--) begin
            serve(s, VW'(s));
            do_rti(0, s);
        end

        // R2 lower and equal requests stay pending
        raise(2);
        serve(2, 8'h40);
        raise(1);
        raise(2);
        quiet(5, "R2 lower or equal held");
        do_rti(0, 2);
        serve(2, 8'h41);
        do_rti(0, 2);
        serve(1, 8'h42);
        do_rti(0, 1);

        // R7 R9 nesting at every level, then unwind
        for (int s = 0; s <= NSRC; s++) begin
            raise(s);
            serve(s, VW'(8'h80 + s));
        end
        check("R9 no overflow at full depth", nest_ovf, 0);
        for (int s = NSRC; s >= 0; s--) do_rti(s, s);
        check("R9 no overflow after unwind", nest_ovf, 0);

        // R6 vector timeout
        serve_timeout: begin
            raise(0);
            serve(0, 8'h01);
            raise(2);
            cnt = 0;
            while (!cpu_irq && cnt < 12) begin @(negedge clk); cnt++; end
            cpu_ack = 1'b1;
            @(negedge clk);
            cpu_ack = 1'b0;
            drop(2);
            cnt = 0;
            while (dev_ack != '0 && cnt < 20) begin cnt++; @(negedge clk); end
            check("R6 ack cycles before timeout", cnt, TO);
            check("R6 bus_err raised", bus_err, 1);
            check("R6 no dispatch", handler_valid, 0);
            @(negedge clk);
            check("R6 bus_err one cycle", bus_err, 0);
            check("R6 cur_prio unchanged", cur_prio, 1);
            check("R6 isr_latch unchanged", isr_latch, exp_latch);
            do_rti(0, 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule